// File: doc/BRIEF.md
# Fetch Target Cache

This block sits beside the instruction fetch stage and remembers where taken branches went. It is a direct-mapped table. Each slot holds a valid flag, a tag cut from the branch address, and the full address that the branch jumped to. Every fetch address is looked up. The block reports whether that address is a branch it has seen before, and it gives the address to fetch next.

The block does not predict direction. A separate direction predictor drives a taken/not-taken bit alongside each fetch address. On a hit, that bit chooses between the stored target and the sequential address. On a miss, the fetch is treated as an ordinary instruction and the sequential address is returned.

When a branch resolves as taken, the execute side writes its address and target through the update port. The write claims the slot whatever was in it before. Lookups are pipelined over two clock edges: the first edge reads the table, and the second registers the decision.

Top module: `fetch_target_cache`

## Requirements
- R1: After reset every slot is empty, so every lookup made after reset and before any taken update reports is_branch = 0.
- R2: out_valid is asserted exactly two rising edges after a cycle with fe_valid = 1, and is low at all other times, including while rst is high.
- R3: The slot index is fetch PC bits [IDX_W+1:2]. The tag is PC bits [PC_W-1:IDX_W+2]. A lookup hits only if the slot is valid and its stored tag equals the tag of the fetch PC, so addresses that share an index but differ in any tag bit do not hit each other's slot.
- R4: On a hit with fe_dir_taken = 1, out_next_pc equals the target that was stored for that slot, and out_is_branch = 1.
- R5: On a hit with fe_dir_taken = 0, out_next_pc = out_pc + 4 and out_is_branch = 1.
- R6: On a miss, out_is_branch = 0 and out_next_pc = out_pc + 4, modulo 2^PC_W (so 0xFFFFFFFC is followed by 0).
- R7: An update with upd_valid = 1 and upd_taken = 1 writes the tag, target and valid flag into the slot selected by upd_pc_word. Any earlier occupant of that slot, including one with a different tag, is replaced.
- R8: An update with upd_taken = 0 changes no slot. A later lookup of that address returns the same result it would have returned without the update.
- R9: A lookup and an update to the same slot in the same cycle return the slot contents from before the update. A lookup one cycle later sees the new contents.
- R10: out_pc carries the fetch PC of the lookup being reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | A fetch address is presented this cycle |
| fe_pc | input | PC_W | Fetch address (byte address, word aligned) |
| fe_dir_taken | input | 1 | Direction from the external predictor for this fetch |
| upd_valid | input | 1 | Resolved branch is presented this cycle |
| upd_pc_word | input | PC_W-2 | Word address of the resolved branch (byte address shifted right by two) |
| upd_target | input | PC_W | Resolved target address |
| upd_taken | input | 1 | Resolved branch was taken; only then is the slot written |
| out_valid | output | 1 | A lookup result is reported |
| out_pc | output | PC_W | Fetch address of the reported lookup |
| out_is_branch | output | 1 | Lookup hit a valid slot with a matching tag |
| out_next_pc | output | PC_W | Address to fetch next |

## Verification
The hardest case to reach is a lookup and a taken update that land on the same slot in the same cycle. Here the read-first order of the table decides the result. The stimulus creates this case by driving both ports in one cycle to a fresh slot, then repeats the lookup in the following cycle. It also builds index aliasing by choosing two addresses whose bits above the index differ. It writes one of them, then the other, and shows that the first no longer hits. The same checks are made for an address that differs only in its most significant bit.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  // How a lookup result was formed
  typedef enum logic [1:0] {
    ROUTE_SEQ_MISS  = 2'd0,
    ROUTE_SEQ_HIT   = 2'd1,
    ROUTE_JUMP_HIT  = 2'd2
  } ftc_route_e;

  localparam int unsigned FTC_BYTE_OFS_W = 2;
  localparam int unsigned FTC_INSN_BYTES = 4;

endpackage

// File: rtl/ftc_field_split.sv
module ftc_field_split #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned WRD_W = PC_W - 2,
  localparam int unsigned TAG_W = WRD_W - IDX_W
) (
  input  logic [WRD_W-1:0] word_addr,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = word_addr[IDX_W-1:0];
  assign tag = word_addr[WRD_W-1:IDX_W];
endmodule

// File: rtl/ftc_entry_store.sv
module ftc_entry_store #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned DATA_W = 56,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_live
);
  // Payload array: no reset, synchronous read-first port, RAM friendly
  logic [DATA_W-1:0] payload [DEPTH];
  // Occupancy flags kept in flops so reset can clear them in one cycle
  logic [DEPTH-1:0]  live_q;

  always_ff @(posedge clk) begin
    if (wr_en) payload[wr_idx] <= wr_data;
    rd_data <= payload[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      rd_live <= 1'b0;
    end else begin
      if (wr_en) live_q[wr_idx] <= 1'b1;
      rd_live <= live_q[rd_idx];
    end
  end
endmodule

// File: rtl/ftc_route.sv
module ftc_route
  import ftc_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_vld,
  input  logic [PC_W-1:0]  s1_pc,
  input  logic             s1_dir,
  input  logic [TAG_W-1:0] s1_tag,
  input  logic             ent_live,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [PC_W-1:0]  ent_target,
  output logic             out_valid,
  output logic [PC_W-1:0]  out_pc,
  output logic             out_is_branch,
  output logic [PC_W-1:0]  out_next_pc
);
  logic            hit;
  ftc_route_e      route;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] next_pc;

  assign hit    = ent_live && (ent_tag == s1_tag);
  assign seq_pc = s1_pc + PC_W'(FTC_INSN_BYTES);

  always_comb begin
    if (!hit)       route = ROUTE_SEQ_MISS;
    else if (s1_dir) route = ROUTE_JUMP_HIT;
    else            route = ROUTE_SEQ_HIT;
  end

  always_comb begin
    unique case (route)
      ROUTE_JUMP_HIT: next_pc = ent_target;
      default:        next_pc = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_pc        <= '0;
      out_is_branch <= 1'b0;
      out_next_pc   <= '0;
    end else begin
      out_valid     <= s1_vld;
      out_pc        <= s1_pc;
      out_is_branch <= (route != ROUTE_SEQ_MISS);
      out_next_pc   <= next_pc;
    end
  end
endmodule

// File: rtl/fetch_target_cache.sv
module fetch_target_cache #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned WRD_W  = PC_W - 2,
  localparam int unsigned TAG_W  = WRD_W - IDX_W,
  localparam int unsigned DATA_W = TAG_W + PC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fe_valid,
  input  logic [PC_W-1:0]  fe_pc,
  input  logic             fe_dir_taken,
  input  logic             upd_valid,
  input  logic [WRD_W-1:0] upd_pc_word,
  input  logic [PC_W-1:0]  upd_target,
  input  logic             upd_taken,
  output logic             out_valid,
  output logic [PC_W-1:0]  out_pc,
  output logic             out_is_branch,
  output logic [PC_W-1:0]  out_next_pc
);
  logic [IDX_W-1:0] fe_idx, up_idx;
  logic [TAG_W-1:0] fe_tag, up_tag;

  // One splitter per address source
  ftc_field_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_fetch (
    .word_addr (fe_pc[PC_W-1:2]),
    .idx       (fe_idx),
    .tag       (fe_tag)
  );
  ftc_field_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_update (
    .word_addr (upd_pc_word),
    .idx       (up_idx),
    .tag       (up_tag)
  );

  // Only resolved taken branches claim a slot
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              rd_live;

  assign wr_en   = upd_valid && upd_taken;
  assign wr_data = {up_tag, upd_target};

  ftc_entry_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (up_idx),
    .wr_data (wr_data),
    .rd_idx  (fe_idx),
    .rd_data (rd_data),
    .rd_live (rd_live)
  );

  // Stage 1: fetch context travels alongside the table read
  logic             s1_vld, s1_dir;
  logic [PC_W-1:0]  s1_pc;
  logic [TAG_W-1:0] s1_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_dir <= 1'b0;
      s1_pc  <= '0;
      s1_tag <= '0;
    end else begin
      s1_vld <= fe_valid;
      s1_dir <= fe_dir_taken;
      s1_pc  <= fe_pc;
      s1_tag <= fe_tag;
    end
  end

  // Stage 2: compare, choose, register
  ftc_route #(.PC_W(PC_W), .TAG_W(TAG_W)) u_route (
    .clk           (clk),
    .rst           (rst),
    .s1_vld        (s1_vld),
    .s1_pc         (s1_pc),
    .s1_dir        (s1_dir),
    .s1_tag        (s1_tag),
    .ent_live      (rd_live),
    .ent_tag       (rd_data[DATA_W-1:PC_W]),
    .ent_target    (rd_data[PC_W-1:0]),
    .out_valid     (out_valid),
    .out_pc        (out_pc),
    .out_is_branch (out_is_branch),
    .out_next_pc   (out_next_pc)
  );
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fe_valid,
  input logic [PC_W-1:0] fe_pc,
  input logic            fe_dir_taken,
  input logic            out_valid,
  input logic [PC_W-1:0] out_pc,
  input logic            out_is_branch,
  input logic [PC_W-1:0] out_next_pc
);
  AST_RESULT_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (rst)
    fe_valid |=> ##1 out_valid);  // R2

  AST_NO_RESULT_WITHOUT_FETCH: assert property (@(posedge clk) disable iff (rst)
    !fe_valid |=> ##1 !out_valid);  // R2

  AST_MISS_IS_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_is_branch) |-> out_next_pc == out_pc + PC_W'(4));  // R6

  AST_NOT_TAKEN_IS_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_branch && !$past(fe_dir_taken, 2)) |-> out_next_pc == out_pc + PC_W'(4));  // R5

  AST_REDIRECT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_next_pc != out_pc + PC_W'(4)) |-> out_is_branch);  // R4

  AST_PC_ECHO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_pc == $past(fe_pc, 2));  // R10
endmodule

bind fetch_target_cache ftc_checker #(.PC_W(PC_W)) u_ftc_checker (
  .clk           (clk),
  .rst           (rst),
  .fe_valid      (fe_valid),
  .fe_pc         (fe_pc),
  .fe_dir_taken  (fe_dir_taken),
  .out_valid     (out_valid),
  .out_pc        (out_pc),
  .out_is_branch (out_is_branch),
  .out_next_pc   (out_next_pc)
);

// File: tb/fetch_target_cache_bench.sv
module fetch_target_cache_bench;
  localparam int unsigned PC_W  = 32;
  localparam int unsigned IDX_W = 6;
  localparam int unsigned WRD_W = PC_W - 2;
  localparam int unsigned TAG_W = WRD_W - IDX_W;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fe_valid = 1'b0;
  logic [PC_W-1:0]  fe_pc = '0;
  logic             fe_dir_taken = 1'b0;
  logic             upd_valid = 1'b0;
  logic [WRD_W-1:0] upd_pc_word = '0;
  logic [PC_W-1:0]  upd_target = '0;
  logic             upd_taken = 1'b0;
  logic             out_valid;
  logic [PC_W-1:0]  out_pc;
  logic             out_is_branch;
  logic [PC_W-1:0]  out_next_pc;

  always #2 clk = ~clk;  // 250 MHz

  fetch_target_cache #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fetch_target_cache (
    .clk (clk), .rst (rst),
    .fe_valid (fe_valid), .fe_pc (fe_pc), .fe_dir_taken (fe_dir_taken),
    .upd_valid (upd_valid), .upd_pc_word (upd_pc_word),
    .upd_target (upd_target), .upd_taken (upd_taken),
    .out_valid (out_valid), .out_pc (out_pc),
    .out_is_branch (out_is_branch), .out_next_pc (out_next_pc)
  );

  typedef struct {
    logic [PC_W-1:0] pc;
    logic            br;
    logic [PC_W-1:0] nxt;
    string           req;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // Reference table built from the requirements
  logic             m_live [DEPTH];
  logic [TAG_W-1:0] m_tag  [DEPTH];
  logic [PC_W-1:0]  m_tgt  [DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; expectations use contents before this cycle's write (R9)
  task automatic step(input bit lk, input logic [PC_W-1:0] pc, input bit dir,
                      input bit up, input logic [PC_W-1:0] ubyte,
                      input logic [PC_W-1:0] utgt, input bit utk, input string req);
    exp_t e;
    int   ix;
    logic [TAG_W-1:0] tg;
    bit   hit;
    @(negedge clk);
    fe_valid     = lk;
    fe_pc        = pc;
    fe_dir_taken = dir;
    upd_valid    = up;
    upd_pc_word  = ubyte[PC_W-1:2];
    upd_target   = utgt;
    upd_taken    = utk;
    if (lk) begin
      ix    = int'(pc[IDX_W+1:2]);
      tg    = pc[PC_W-1:IDX_W+2];
      hit   = m_live[ix] && (m_tag[ix] == tg);
      e.pc  = pc;
      e.br  = hit;
      e.nxt = (hit && dir) ? m_tgt[ix] : pc + PC_W'(4);
      e.req = req;
      expq.push_back(e);
    end
    if (up && utk) begin
      ix = int'(ubyte[IDX_W+1:2]);
      m_live[ix] = 1'b1;
      m_tag[ix]  = ubyte[PC_W-1:IDX_W+2];
      m_tgt[ix]  = utgt;
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input bit dir, input string req);
    step(1'b1, pc, dir, 1'b0, '0, '0, 1'b0, req);
  endtask

  task automatic learn(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt,
                       input bit tk, input string req);
    step(1'b0, '0, 1'b0, 1'b1, pc, tgt, tk, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, "R2");
  endtask

  // Monitor: pops one expectation for each reported result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2", "unexpected out_valid", PC_W'(1), '0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(out_pc == e.pc, "R10", "out_pc", out_pc, e.pc);
        check(out_is_branch == e.br, e.req, "out_is_branch",
              PC_W'(out_is_branch), PC_W'(e.br));
        check(out_next_pc == e.nxt, e.req, "out_next_pc", out_next_pc, e.nxt);
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_live[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    // Reset state: no results while rst is high (R2)
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R2", "out_valid in reset", PC_W'(out_valid), '0);
    end
    rst = 1'b0;

    // R1: empty table after reset
    look(32'h0000_0000, 1'b1, "R1");
    look(32'h0000_0004, 1'b1, "R1");
    look(32'h0000_0100, 1'b0, "R1");
    look(32'h0000_00FC, 1'b1, "R1");

    // R7, R4, R5: write then look both directions
    learn(32'h0000_1000, 32'h0000_2000, 1'b1, "R7");
    look(32'h0000_1000, 1'b1, "R4");
    look(32'h0000_1000, 1'b0, "R5");

    // R8: not-taken update is ignored
    learn(32'h0000_1040, 32'h0000_5550, 1'b0, "R8");
    look(32'h0000_1040, 1'b1, "R8");

    // R7 aliasing: same index, different tag replaces the slot
    learn(32'h0000_1100, 32'h0000_3000, 1'b1, "R7");
    look(32'h0000_1000, 1'b1, "R7");
    look(32'h0000_1100, 1'b1, "R7");
    // R3: differs only in the top bit
    look(32'h8000_1100, 1'b1, "R3");

    // R9: same-cycle write and read, then read again
    step(1'b1, 32'h0000_2208, 1'b1, 1'b1, 32'h0000_2208, 32'h0000_0040, 1'b1, "R9");
    look(32'h0000_2208, 1'b1, "R9");

    // R6: sequential address wraps
    look(32'hFFFF_FFFC, 1'b1, "R6");

    // Fill every slot back to back, then read with gaps
    for (int i = 0; i < DEPTH; i++)
      learn(32'h0004_0000 + 32'(i * 4), 32'h0000_8000 + 32'(i * 16), 1'b1, "R7");
    for (int i = 0; i < DEPTH; i++) begin
      look(32'h0004_0000 + 32'(i * 4), (i % 3) != 0, "R4");
      if (i % 5 == 0) idle(1);
    end
    // Old occupants evicted by the fill
    look(32'h0000_1100, 1'b1, "R7");
    look(32'h0000_2208, 1'b0, "R7");

    idle(4);
    check(expq.size() == 0, "R2", "results missing", PC_W'(expq.size()), '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=%h expected=%h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule